// File: doc/BRIEF.md
# CSD Shift-Add Constant Multiplier

This block scales a signed 16-bit sample by a constant coefficient, such as a twiddle factor, using no array multiplier. The coefficient is held as a string of canonical signed digits, each worth 0, +1 or -1. Every digit position has a fixed shift of the input. A nonzero digit adds or subtracts its shifted copy into the result, and a zero digit contributes nothing. The full-precision sum is truncated by dropping a fixed number of fraction bits. The result is registered one cycle after the request.

The coefficient comes from one of two sources:
- **Digit form.** The caller supplies the digit string directly.
- **Binary form.** The caller supplies an ordinary two's complement word. A combinational recoder turns it into a digit string in which no two neighbouring digits are both nonzero.

A 2-bit code pattern that names no digit value is reported alongside the result.

Top module: `csd_mult`

## Requirements
- R1: With `coef_sel`=0, each 2-bit field k of `coef_dig` (bits 2k+1:2k) is a digit of weight 2^k. Code 00 means 0, code 01 means +1 and code 11 means -1. The full product equals `in_data` times the sum of digit times 2^k.
- R2: Code 10 in any field of `coef_dig` contributes nothing to the product. When it is present and `coef_sel`=0, `out_bad` is 1 together with that result. Otherwise `out_bad` is 0.
- R3: With `coef_sel`=1, `coef_bin` (16-bit two's complement) is recoded into 17 digits. The weighted digit sum equals the signed value of `coef_bin`. The product uses those digits, and `out_bad` is 0.
- R4: The recoded digit string never holds two nonzero digits at adjacent positions, and it never uses code 10.
- R5: `out_data` is the 33-bit full product shifted arithmetically right by 15 bits (truncation toward minus infinity), giving 18 bits.
- R6: A request accepted with `in_valid`=1 at a rising edge appears on `out_data`/`out_bad` after that edge, with `out_valid`=1. `out_valid` is 0 after any edge where `in_valid` was 0.
- R7: While `in_valid` is 0, `out_data` and `out_bad` keep their values, whatever the other inputs do.
- R8: While `rst_n` is low, `out_valid`, `out_data` and `out_bad` are 0.
- R9: Extreme operands are exact: -32768 times a coefficient of -32768 yields 2^30 before truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 16 | Signed sample to scale |
| coef_sel | input | 1 | 1 = use binary coefficient, 0 = use digit string |
| coef_bin | input | 16 | Two's complement coefficient |
| coef_dig | input | 34 | 17 digit codes, 2 bits each, position 0 in the low bits |
| out_valid | output | 1 | Result strobe |
| out_data | output | 18 | Truncated signed product |
| out_bad | output | 1 | Result used an illegal digit code |

## Verification
The recoder's freedom from adjacent nonzero digits cannot be seen at the multiplier's ports, because a correct product hides which digit string produced it. The bench therefore runs a second, standalone recoder instance over every one of the 65536 binary coefficients and checks both the digit value and the adjacency rule. Products at the range extremes are reached through a sweep of edge samples against a coarse grid of coefficients. Random digit strings seeded with illegal codes check that such codes add nothing while still raising the flag.

// File: rtl/csd_pkg.sv
package csd_pkg;
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_PLUS = 2'b01,
        DIG_BAD  = 2'b10,
        DIG_MINUS = 2'b11
    } dig_e;
endpackage

// File: rtl/csd_recoder.sv
module csd_recoder #(
    parameter int CW = 16,
    localparam int ND = CW + 1
) (
    input  logic [CW-1:0]   coef,
    output logic [2*ND-1:0] digits
);
    import csd_pkg::*;

    // carry-based recoding, LSB first, over a twice sign-extended word
    always_comb begin
        logic [CW+1:0] b;
        logic          c;
        b = {{2{coef[CW-1]}}, coef};
        c = 1'b0;
        digits = '0;
        for (int i = 0; i < ND; i++) begin
            if ((b[i] ^ c) == 1'b1) begin
                digits[2*i +: 2] = b[i+1] ? DIG_MINUS : DIG_PLUS;
                c = b[i+1];
            end else begin
                digits[2*i +: 2] = DIG_ZERO;
                c = b[i];
            end
        end
    end
endmodule

// File: rtl/csd_term.sv
module csd_term #(
    parameter int DW  = 16,
    parameter int PW  = 33,
    parameter int POS = 0
) (
    input  logic signed [DW-1:0] x,
    input  logic [1:0]           code,
    output logic signed [PW-1:0] term,
    output logic                 bad
);
    import csd_pkg::*;

    logic signed [PW-1:0] shifted;

    always_comb begin
        shifted = PW'(x) <<< POS;
        bad     = 1'b0;
        case (dig_e'(code))
            DIG_PLUS:  term = shifted;
            DIG_MINUS: term = -shifted;
            DIG_BAD: begin
                term = '0;
                bad  = 1'b1;
            end
            default:   term = '0;
        endcase
    end
endmodule

// File: rtl/csd_mult.sv
module csd_mult #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 15,
    localparam int ND = CW + 1,
    localparam int PW = DW + ND,
    localparam int OW = PW - FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic                 coef_sel,
    input  logic signed [CW-1:0] coef_bin,
    input  logic [2*ND-1:0]      coef_dig,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_data,
    output logic                 out_bad
);
    typedef struct packed {
        logic                 vld;
        logic                 bad;
        logic signed [OW-1:0] dat;
    } st_t;

    st_t st_d, st_q;

    logic [2*ND-1:0]      rec_dig;
    logic [2*ND-1:0]      sel_dig;
    logic signed [PW-1:0] term_w [ND];
    logic [ND-1:0]        bad_w;
    logic signed [PW-1:0] acc;

    csd_recoder #(.CW(CW)) u_rec (
        .coef   (coef_bin),
        .digits (rec_dig)
    );

    assign sel_dig = coef_sel ? rec_dig : coef_dig;

    for (genvar g = 0; g < ND; g++) begin : g_term
        csd_term #(.DW(DW), .PW(PW), .POS(g)) u_term (
            .x    (in_data),
            .code (sel_dig[2*g +: 2]),
            .term (term_w[g]),
            .bad  (bad_w[g])
        );
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < ND; i++) acc = acc + term_w[i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.dat = acc[PW-1:FRAC];
            st_d.bad = |bad_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;
    assign out_bad   = st_q.bad;

    // checks on the recoder output
    int          rec_val;
    logic [ND-1:0] rec_nz;
    always_comb begin
        rec_val = 0;
        for (int i = 0; i < ND; i++) begin
            rec_nz[i] = rec_dig[2*i] | rec_dig[2*i+1];
            if (rec_dig[2*i +: 2] == 2'b01) rec_val = rec_val + (1 <<< i);
            if (rec_dig[2*i +: 2] == 2'b11) rec_val = rec_val - (1 <<< i);
        end
    end

    AST_REC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_val == int'(coef_bin)); // R3
    AST_NO_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_nz & (rec_nz >> 1)) == '0); // R4
    AST_REC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && coef_sel |=> !out_bad); // R2
    AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R6
    AST_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data) && $stable(out_bad)); // R7
endmodule

// File: tb/tb_csd_mult.sv
module tb_csd_mult;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               coef_sel = 1'b0;
    logic signed [15:0] coef_bin = '0;
    logic [33:0]        coef_dig = '0;
    logic               out_valid;
    logic signed [17:0] out_data;
    logic               out_bad;

    logic [15:0] rc_coef = '0;
    logic [33:0] rc_dig;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    csd_mult dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .coef_sel(coef_sel), .coef_bin(coef_bin), .coef_dig(coef_dig),
        .out_valid(out_valid), .out_data(out_data), .out_bad(out_bad)
    );

    csd_recoder #(.CW(16)) u_chk_rec (.coef(rc_coef), .digits(rc_dig));

    function automatic int dig_sum(input logic [33:0] d);
        int v = 0;
        for (int i = 0; i < 17; i++) begin
            if (d[2*i +: 2] == 2'b01) v += (1 << i);
            if (d[2*i +: 2] == 2'b11) v -= (1 << i);
        end
        return v;
    endfunction

    function automatic bit has_bad(input logic [33:0] d);
        for (int i = 0; i < 17; i++) if (d[2*i +: 2] == 2'b10) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive at negedge, result visible one negedge later
    task automatic run_op(input string req, input logic signed [15:0] x,
                          input logic sel, input logic signed [15:0] cb,
                          input logic [33:0] cd);
        longint p;
        logic signed [17:0] e;
        in_valid = 1'b1; in_data = x; coef_sel = sel; coef_bin = cb; coef_dig = cd;
        p = longint'(x) * (sel ? longint'(cb) : longint'(dig_sum(cd)));
        e = 18'(p >>> 15);
        @(negedge clk);
        check({req, " data"}, longint'(out_data), longint'(e));
        check({req, " valid"}, longint'(out_valid), 1);
        check({req, " bad"}, longint'(out_bad), sel ? 0 : longint'(has_bad(cd)));
    endtask

    function automatic logic [33:0] rand_dig(input bit allow_bad);
        logic [33:0] d;
        for (int i = 0; i < 17; i++) begin
            case ($urandom % (allow_bad ? 4 : 3))
                0: d[2*i +: 2] = 2'b00;
                1: d[2*i +: 2] = 2'b01;
                2: d[2*i +: 2] = 2'b11;
                default: d[2*i +: 2] = 2'b10;
            endcase
        end
        return d;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic signed [15:0] xs [6];
        xs[0] = -16'sd32768; xs[1] = -16'sd1; xs[2] = 16'sd0;
        xs[3] = 16'sd1; xs[4] = 16'sd32767; xs[5] = 16'sd12345;

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8 valid", longint'(out_valid), 0);
        check("R8 data", longint'(out_data), 0);
        check("R8 bad", longint'(out_bad), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: directed single digits
        run_op("R1 top plus", 16'sd3, 1'b0, '0, 34'b01 << 32);
        run_op("R1 low minus", 16'sd32767, 1'b0, '0, 34'b11);
        // R1: random legal digit strings
        for (int k = 0; k < 1500; k++)
            run_op("R1", 16'($urandom), 1'b0, '0, rand_dig(1'b0));

        // R2: illegal codes ignored but flagged
        run_op("R2 all bad", 16'sd1000, 1'b0, '0, {17{2'b10}});
        for (int k = 0; k < 1500; k++)
            run_op("R2", 16'($urandom), 1'b0, '0, rand_dig(1'b1));

        // R3 R5: binary sweep across coefficient grid and edge samples
        for (int c = -32768; c < 32768; c += 257)
            for (int j = 0; j < 6; j++)
                run_op("R3 R5", xs[j], 1'b1, 16'(c), '0);
        for (int j = 0; j < 6; j++) begin
            run_op("R5 cmax", xs[j], 1'b1, 16'sd32767, '0);
            run_op("R5 cmin", xs[j], 1'b1, -16'sd32768, '0);
        end

        // R9: extreme operands
        run_op("R9", -16'sd32768, 1'b1, -16'sd32768, '0);
        check("R9 exact", longint'(out_data), 32768);

        // R6 R7: idle cycles hold result, drop valid
        run_op("R7 setup", 16'sd777, 1'b0, '0, {17{2'b10}});
        begin
            logic signed [17:0] hd;
            logic hb;
            hd = out_data; hb = out_bad;
            in_valid = 1'b0; in_data = 16'sd5; coef_sel = 1'b1; coef_bin = 16'sd99;
            coef_dig = '0;
            @(negedge clk);
            check("R6 valid low", longint'(out_valid), 0);
            check("R7 data held", longint'(out_data), longint'(hd));
            check("R7 bad held", longint'(out_bad), longint'(hb));
            in_data = -16'sd300;
            @(negedge clk);
            check("R7 data held2", longint'(out_data), longint'(hd));
        end

        // R3 R4: exhaustive standalone recoder sweep
        for (int c = 0; c < 65536; c++) begin
            logic [16:0] nz;
            rc_coef = 16'(c);
            #1;
            check("R3 recode value", longint'(dig_sum(rc_dig)), longint'($signed(16'(c))));
            for (int i = 0; i < 17; i++) nz[i] = rc_dig[2*i] | rc_dig[2*i+1];
            tests++;
            if (((nz & (nz >> 1)) != '0) || has_bad(rc_dig)) begin
                fails++;
                $display("FAIL R4 coef %0d: actual digits %b expected no adjacent nonzero",
                         c, rc_dig);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule